// File: doc/BRIEF.md
# Clock-crossing ADC result read bridge

This block sits between a bus-side register port, clocked by the peripheral clock, and a converter whose result and FIFO-status values live in a separate converter clock domain. In asynchronous mode, a bus access to one of the crossed addresses starts a toggle request/acknowledge handshake. The request passes through two flops in each direction. The bus sees `bus_ready_o` low until the acknowledge has returned, then completes the access with the value captured on the converter side. Writes to the two FIFO-clear addresses cross the same way and come out as single-cycle clear pulses in the converter domain. In synchronous mode both sides run from one clock, so the handshake is bypassed and every access completes with zero wait states.

The bridge also holds the converter's control registers and its mode register, and it issues the stop commands. A control write is accepted only while the matching sequence (single or scan) is idle and has no trigger pending. A write attempted at any other time is dropped and raises a sticky error flag. Software first issues a stop command, waits for the active flag to fall, and only then reprograms the control registers. In asynchronous mode the peripheral clock must run at least 1.5 times as fast as the converter clock, which keeps the stall within 7 cycles.

Top module: `adc_xb_bridge`

## Requirements
- R1: With address 0 bit 0 set (asynchronous mode), a read of a crossed source address holds `bus_ready_o` low for at least 1 and at most 7 cycles. The read then returns slice (address - 8) of `cnv_src_i`. The source addresses are: 8 single result, 9 single previous result, 10 scan result, 11 scan previous result, 12 scan extended result, 13 single FIFO count, 14 scan FIFO count.
- R2: With address 0 bit 0 clear (synchronous mode, converter clock equal to the bus clock), accesses to addresses 8 to 16 complete in their first cycle, and reads of 8 to 14 return the matching `cnv_src_i` slice.
- R3: Accesses to addresses 0 to 7 complete with zero wait states in both modes.
- R4: A write to address 15 gives exactly one `cnv_clk` cycle pulse on `clr_single_o`, and a write to address 16 gives one on `clr_scan_o`. The other output does not pulse. In asynchronous mode such a write stalls for 1 to 7 cycles.
- R5: A write to address 3 (single control) is applied only when `single_act_i` and `single_trig_pend_i` are both 0. Otherwise the register keeps its value and `wr_err_o` is set.
- R6: Writes to addresses 4 to 7 (scan control, scan input select, scan negative select, scan mask) are guarded only by `scan_act_i` and `scan_trig_pend_i`, with the same drop-and-error behaviour. The single-sequence flags have no effect on them.
- R7: `wr_err_o` stays 1 until a write to address 2 with bit 2 set. A read of address 2 returns the error flag in bit 2, `scan_act_i` in bit 1 and `single_act_i` in bit 0.
- R8: A write to address 1 raises `stop_single_o` for one cycle in the following cycle if bit 0 is set, and `stop_scan_o` likewise if bit 1 is set.
- R9: Address 0 bit 0 drives `clk_async_o` and bit 1 drives `clk_inv_o` (inverted converter clock source). Both bits read back.
- R10: After reset the mode register, the control registers and the error flag are 0, and no stop or clear pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Peripheral (bus) clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| cnv_clk | input | 1 | Converter clock |
| cnv_rst | input | 1 | Synchronous active-high reset, converter domain |
| bus_sel_i | input | 1 | Access request, held until ready |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Register word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid when ready |
| bus_ready_o | output | 1 | Access completes in this cycle |
| single_act_i | input | 1 | Single sequence active (bus domain) |
| scan_act_i | input | 1 | Scan sequence active (bus domain) |
| single_trig_pend_i | input | 1 | Single trigger pending (bus domain) |
| scan_trig_pend_i | input | 1 | Scan trigger pending (bus domain) |
| cnv_src_i | input | 7*DATA_W | Converter-side result and count values, slice k for address 8+k |
| clk_async_o | output | 1 | Asynchronous converter clock selected |
| clk_inv_o | output | 1 | Inverted asynchronous clock source selected |
| sgl_ctrl_o | output | DATA_W | Single control register |
| scn_ctrl_o | output | DATA_W | Scan control register |
| scn_insel_o | output | DATA_W | Scan input select register |
| scn_negsel_o | output | DATA_W | Scan negative select register |
| scn_mask_o | output | DATA_W | Scan mask register |
| stop_single_o | output | 1 | Stop pulse for the single sequence |
| stop_scan_o | output | 1 | Stop pulse for the scan sequence |
| clr_single_o | output | 1 | Single FIFO clear pulse, converter domain |
| clr_scan_o | output | 1 | Scan FIFO clear pulse, converter domain |
| wr_err_o | output | 1 | Sticky dropped-control-write flag |

## Verification
The assertions assume the following about the inputs:
- the bus master holds select, direction, address and write data steady until ready;
- the converter-side source values do not move while a crossing is in flight;
- the mode changes only between accesses;
- the converter clock runs slower than the bus clock by the stated ratio but not so slow that the 7-cycle bound breaks.

The stimulus respects these assumptions. It changes sources and status flags only between accesses, runs the converter clock at 1.6 times the bus period, and switches the converter clock onto the bus clock only after synchronous mode has been written and the handshake is idle.

// File: rtl/adc_xb_pkg.sv
package adc_xb_pkg;

    localparam int unsigned XB_AW       = 5;
    localparam int unsigned NUM_CTRL    = 5;
    localparam int unsigned NUM_SRC     = 7;
    localparam int unsigned XB_MAX_WAIT = 7;

    typedef logic [XB_AW-1:0] xb_addr_t;

    localparam xb_addr_t A_CFG     = 5'd0;
    localparam xb_addr_t A_CMD     = 5'd1;
    localparam xb_addr_t A_STAT    = 5'd2;
    localparam xb_addr_t A_CTRL0   = 5'd3;
    localparam xb_addr_t A_SRC0    = 5'd8;
    localparam xb_addr_t A_CLR_SGL = 5'd15;
    localparam xb_addr_t A_CLR_SCN = 5'd16;

    localparam int unsigned STAT_ERR_BIT = 2;

    typedef enum logic [0:0] {
        HS_IDLE = 1'b0,
        HS_WAIT = 1'b1
    } hs_state_e;

    typedef struct packed {
        xb_addr_t addr;
        logic     wr;
    } xb_req_t;

    function automatic logic is_crossed(xb_addr_t a);
        return (a >= A_SRC0) && (a <= A_CLR_SCN);
    endfunction

    function automatic logic is_ctrl(xb_addr_t a);
        return (a >= A_CTRL0) && (a < A_CTRL0 + XB_AW'(NUM_CTRL));
    endfunction

    function automatic int unsigned src_index(xb_addr_t a);
        return 32'(a) - 32'(A_SRC0);
    endfunction

endpackage

// File: rtl/adc_xb_bus_hs.sv
module adc_xb_bus_hs
    import adc_xb_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sel_i,
    input  logic                      wr_i,
    input  xb_addr_t                  addr_i,
    input  logic                      async_i,
    input  logic                      ack_tgl_i,
    input  logic [DATA_W-1:0]         hold_i,
    input  logic [NUM_SRC*DATA_W-1:0] src_i,
    output logic                      req_tgl_o,
    output xb_req_t                   req_o,
    output logic                      ready_o,
    output logic [DATA_W-1:0]         rdata_o
);

    hs_state_e   state_q;
    logic        ack_s1_q;
    logic        ack_s2_q;
    logic        done;
    logic        start;
    logic [DATA_W-1:0] direct_val;

    assign start = sel_i && async_i && is_crossed(addr_i) && (state_q == HS_IDLE);
    assign done  = (state_q == HS_WAIT) && (ack_s2_q == req_tgl_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= HS_IDLE;
            req_tgl_o <= 1'b0;
            req_o     <= '0;
            ack_s1_q  <= 1'b0;
            ack_s2_q  <= 1'b0;
        end else begin
            ack_s1_q <= ack_tgl_i;
            ack_s2_q <= ack_s1_q;
            case (state_q)
                HS_IDLE: begin
                    if (start) begin
                        req_tgl_o  <= ~req_tgl_o;
                        req_o.addr <= addr_i;
                        req_o.wr   <= wr_i;
                        state_q    <= HS_WAIT;
                    end
                end
                HS_WAIT: begin
                    if (done) begin
                        state_q <= HS_IDLE;
                    end
                end
                default: state_q <= HS_IDLE;
            endcase
        end
    end

    always_comb begin
        direct_val = '0;
        for (int unsigned k = 0; k < NUM_SRC; k++) begin
            if (src_index(addr_i) == k) begin
                direct_val = src_i[k*DATA_W +: DATA_W];
            end
        end
    end

    assign ready_o = async_i ? done : 1'b1;

    always_comb begin
        if (async_i) begin
            rdata_o = req_o.wr ? '0 : hold_i;
        end else begin
            rdata_o = wr_i ? '0 : direct_val;
        end
    end

endmodule

// File: rtl/adc_xb_cnv_hs.sv
module adc_xb_cnv_hs
    import adc_xb_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_tgl_i,
    input  xb_req_t                   req_i,
    input  logic [NUM_SRC*DATA_W-1:0] src_i,
    input  logic [1:0]                sync_clr_i,
    output logic                      ack_tgl_o,
    output logic [DATA_W-1:0]         hold_o,
    output logic [1:0]                clr_o
);

    logic        req_s1_q;
    logic        req_s2_q;
    logic        new_req;
    logic [DATA_W-1:0] pick;
    logic [1:0]  clr_dec;

    assign new_req = req_s1_q ^ req_s2_q;

    always_comb begin
        pick = '0;
        for (int unsigned k = 0; k < NUM_SRC; k++) begin
            if (src_index(req_i.addr) == k) begin
                pick = src_i[k*DATA_W +: DATA_W];
            end
        end
    end

    assign clr_dec = {req_i.wr && (req_i.addr == A_CLR_SCN),
                      req_i.wr && (req_i.addr == A_CLR_SGL)};

    always_ff @(posedge clk) begin
        if (rst) begin
            req_s1_q <= 1'b0;
            req_s2_q <= 1'b0;
            hold_o   <= '0;
            clr_o    <= '0;
        end else begin
            req_s1_q <= req_tgl_i;
            req_s2_q <= req_s1_q;
            if (new_req) begin
                hold_o <= req_i.wr ? '0 : pick;
                clr_o  <= clr_dec | sync_clr_i;
            end else begin
                clr_o  <= sync_clr_i;
            end
        end
    end

    assign ack_tgl_o = req_s2_q;

endmodule

// File: rtl/adc_xb_regs.sv
module adc_xb_regs
    import adc_xb_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sel_i,
    input  logic                       wr_i,
    input  xb_addr_t                   addr_i,
    input  logic [DATA_W-1:0]          wdata_i,
    input  logic                       single_act_i,
    input  logic                       scan_act_i,
    input  logic                       single_pend_i,
    input  logic                       scan_pend_i,
    output logic                       cfg_async_o,
    output logic                       cfg_inv_o,
    output logic [NUM_CTRL*DATA_W-1:0] ctrl_o,
    output logic                       err_o,
    output logic                       stop_single_o,
    output logic                       stop_scan_o,
    output logic [DATA_W-1:0]          rdata_o
);

    logic                we;
    logic [NUM_CTRL-1:0] drop;
    logic [1:0]          cfg_q;

    assign we = sel_i && wr_i;

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
        localparam bit SCAN_GRP = (g != 0);
        logic              busy;
        logic              hit;
        logic [DATA_W-1:0] val_q;

        assign busy = SCAN_GRP ? (scan_act_i || scan_pend_i)
                               : (single_act_i || single_pend_i);
        assign hit  = we && (addr_i == A_CTRL0 + XB_AW'(g));
        assign drop[g] = hit && busy;

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '0;
            end else if (hit && !busy) begin
                val_q <= wdata_i;
            end
        end

        assign ctrl_o[g*DATA_W +: DATA_W] = val_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q         <= '0;
            err_o         <= 1'b0;
            stop_single_o <= 1'b0;
            stop_scan_o   <= 1'b0;
        end else begin
            if (we && (addr_i == A_CFG)) begin
                cfg_q <= wdata_i[1:0];
            end
            if (|drop) begin
                err_o <= 1'b1;
            end else if (we && (addr_i == A_STAT) && wdata_i[STAT_ERR_BIT]) begin
                err_o <= 1'b0;
            end
            stop_single_o <= we && (addr_i == A_CMD) && wdata_i[0];
            stop_scan_o   <= we && (addr_i == A_CMD) && wdata_i[1];
        end
    end

    assign cfg_async_o = cfg_q[0];
    assign cfg_inv_o   = cfg_q[1];

    always_comb begin
        rdata_o = '0;
        if (!wr_i) begin
            if (addr_i == A_CFG) begin
                rdata_o[1:0] = cfg_q;
            end else if (addr_i == A_STAT) begin
                rdata_o[STAT_ERR_BIT] = err_o;
                rdata_o[1]            = scan_act_i;
                rdata_o[0]            = single_act_i;
            end else begin
                for (int unsigned k = 0; k < NUM_CTRL; k++) begin
                    if (addr_i == A_CTRL0 + XB_AW'(k)) begin
                        rdata_o = ctrl_o[k*DATA_W +: DATA_W];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/adc_xb_bridge.sv
module adc_xb_bridge
    import adc_xb_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic                      bus_clk,
    input  logic                      bus_rst,
    input  logic                      cnv_clk,
    input  logic                      cnv_rst,
    input  logic                      bus_sel_i,
    input  logic                      bus_wr_i,
    input  logic [XB_AW-1:0]          bus_addr_i,
    input  logic [DATA_W-1:0]         bus_wdata_i,
    output logic [DATA_W-1:0]         bus_rdata_o,
    output logic                      bus_ready_o,
    input  logic                      single_act_i,
    input  logic                      scan_act_i,
    input  logic                      single_trig_pend_i,
    input  logic                      scan_trig_pend_i,
    input  logic [NUM_SRC*DATA_W-1:0] cnv_src_i,
    output logic                      clk_async_o,
    output logic                      clk_inv_o,
    output logic [DATA_W-1:0]         sgl_ctrl_o,
    output logic [DATA_W-1:0]         scn_ctrl_o,
    output logic [DATA_W-1:0]         scn_insel_o,
    output logic [DATA_W-1:0]         scn_negsel_o,
    output logic [DATA_W-1:0]         scn_mask_o,
    output logic                      stop_single_o,
    output logic                      stop_scan_o,
    output logic                      clr_single_o,
    output logic                      clr_scan_o,
    output logic                      wr_err_o
);

    localparam int unsigned CTRL_W = NUM_CTRL * DATA_W;

    logic              crossed;
    logic              x_ready;
    logic [DATA_W-1:0] x_rdata;
    logic [DATA_W-1:0] p_rdata;
    logic              req_tgl;
    xb_req_t           req;
    logic              ack_tgl;
    logic [DATA_W-1:0] hold;
    logic [1:0]        sync_clr;
    logic [1:0]        clr;
    logic [CTRL_W-1:0] ctrl_flat;
    logic              direct_wr;

    assign crossed   = is_crossed(bus_addr_i);
    assign direct_wr = bus_sel_i && bus_wr_i && !clk_async_o;
    assign sync_clr  = {direct_wr && (bus_addr_i == A_CLR_SCN),
                        direct_wr && (bus_addr_i == A_CLR_SGL)};

    adc_xb_bus_hs #(.DATA_W(DATA_W)) bus_hs_i (
        .clk       (bus_clk),
        .rst       (bus_rst),
        .sel_i     (bus_sel_i),
        .wr_i      (bus_wr_i),
        .addr_i    (bus_addr_i),
        .async_i   (clk_async_o),
        .ack_tgl_i (ack_tgl),
        .hold_i    (hold),
        .src_i     (cnv_src_i),
        .req_tgl_o (req_tgl),
        .req_o     (req),
        .ready_o   (x_ready),
        .rdata_o   (x_rdata)
    );

    adc_xb_cnv_hs #(.DATA_W(DATA_W)) cnv_hs_i (
        .clk        (cnv_clk),
        .rst        (cnv_rst),
        .req_tgl_i  (req_tgl),
        .req_i      (req),
        .src_i      (cnv_src_i),
        .sync_clr_i (sync_clr),
        .ack_tgl_o  (ack_tgl),
        .hold_o     (hold),
        .clr_o      (clr)
    );

    adc_xb_regs #(.DATA_W(DATA_W)) regs_i (
        .clk           (bus_clk),
        .rst           (bus_rst),
        .sel_i         (bus_sel_i && !crossed),
        .wr_i          (bus_wr_i),
        .addr_i        (bus_addr_i),
        .wdata_i       (bus_wdata_i),
        .single_act_i  (single_act_i),
        .scan_act_i    (scan_act_i),
        .single_pend_i (single_trig_pend_i),
        .scan_pend_i   (scan_trig_pend_i),
        .cfg_async_o   (clk_async_o),
        .cfg_inv_o     (clk_inv_o),
        .ctrl_o        (ctrl_flat),
        .err_o         (wr_err_o),
        .stop_single_o (stop_single_o),
        .stop_scan_o   (stop_scan_o),
        .rdata_o       (p_rdata)
    );

    assign bus_ready_o  = crossed ? x_ready : 1'b1;
    assign bus_rdata_o  = crossed ? x_rdata : p_rdata;
    assign clr_single_o = clr[0];
    assign clr_scan_o   = clr[1];

    assign sgl_ctrl_o   = ctrl_flat[0*DATA_W +: DATA_W];
    assign scn_ctrl_o   = ctrl_flat[1*DATA_W +: DATA_W];
    assign scn_insel_o  = ctrl_flat[2*DATA_W +: DATA_W];
    assign scn_negsel_o = ctrl_flat[3*DATA_W +: DATA_W];
    assign scn_mask_o   = ctrl_flat[4*DATA_W +: DATA_W];

endmodule

// File: rtl/adc_xb_bridge_chk.sv
module adc_xb_bridge_chk
    import adc_xb_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input logic                      bus_clk,
    input logic                      bus_rst,
    input logic                      cnv_clk,
    input logic                      cnv_rst,
    input logic                      bus_sel_i,
    input logic                      bus_wr_i,
    input logic [XB_AW-1:0]          bus_addr_i,
    input logic [DATA_W-1:0]         bus_wdata_i,
    input logic                      bus_ready_o,
    input logic                      single_act_i,
    input logic                      scan_act_i,
    input logic                      single_trig_pend_i,
    input logic                      scan_trig_pend_i,
    input logic                      clk_async_o,
    input logic [DATA_W-1:0]         sgl_ctrl_o,
    input logic [DATA_W-1:0]         scn_ctrl_o,
    input logic [DATA_W-1:0]         scn_insel_o,
    input logic [DATA_W-1:0]         scn_negsel_o,
    input logic [DATA_W-1:0]         scn_mask_o,
    input logic                      clr_single_o,
    input logic                      clr_scan_o,
    input logic                      wr_err_o
);

    logic [7:0] wait_cnt;

    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            wait_cnt <= '0;
        end else if (bus_sel_i && !bus_ready_o) begin
            wait_cnt <= wait_cnt + 8'd1;
        end else begin
            wait_cnt <= '0;
        end
    end

    // R1: a stalled access never waits beyond the bound
    p_wait_bound_r1: assert property (@(posedge bus_clk) disable iff (bus_rst)
        bus_sel_i |-> (32'(wait_cnt) <= XB_MAX_WAIT));

    // R2: synchronous mode never stalls
    p_sync_zero_wait_r2: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (bus_sel_i && !clk_async_o) |-> bus_ready_o);

    // R3: local registers never stall
    p_plain_zero_wait_r3: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (bus_sel_i && !is_crossed(bus_addr_i)) |-> bus_ready_o);

    // R4: the two clear pulses never coincide
    p_clr_excl_r4: assert property (@(posedge cnv_clk) disable iff (cnv_rst)
        $onehot0({clr_single_o, clr_scan_o}));

    // R5: blocked single control write is dropped and flagged
    p_single_guard_r5: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (bus_sel_i && bus_wr_i && (bus_addr_i == A_CTRL0) &&
         (single_act_i || single_trig_pend_i))
        |=> (wr_err_o && $stable(sgl_ctrl_o)));

    // R6: blocked scan group write is dropped and flagged
    p_scan_guard_r6: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (bus_sel_i && bus_wr_i && is_ctrl(bus_addr_i) && (bus_addr_i != A_CTRL0) &&
         (scan_act_i || scan_trig_pend_i))
        |=> (wr_err_o && $stable({scn_ctrl_o, scn_insel_o, scn_negsel_o, scn_mask_o})));

    // R7: error flag holds until explicitly cleared
    p_err_sticky_r7: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (wr_err_o && !(bus_sel_i && bus_wr_i && (bus_addr_i == A_STAT) &&
                       bus_wdata_i[STAT_ERR_BIT]))
        |=> wr_err_o);

endmodule

bind adc_xb_bridge adc_xb_bridge_chk #(.DATA_W(DATA_W)) chk_i (
    .bus_clk            (bus_clk),
    .bus_rst            (bus_rst),
    .cnv_clk            (cnv_clk),
    .cnv_rst            (cnv_rst),
    .bus_sel_i          (bus_sel_i),
    .bus_wr_i           (bus_wr_i),
    .bus_addr_i         (bus_addr_i),
    .bus_wdata_i        (bus_wdata_i),
    .bus_ready_o        (bus_ready_o),
    .single_act_i       (single_act_i),
    .scan_act_i         (scan_act_i),
    .single_trig_pend_i (single_trig_pend_i),
    .scan_trig_pend_i   (scan_trig_pend_i),
    .clk_async_o        (clk_async_o),
    .sgl_ctrl_o         (sgl_ctrl_o),
    .scn_ctrl_o         (scn_ctrl_o),
    .scn_insel_o        (scn_insel_o),
    .scn_negsel_o       (scn_negsel_o),
    .scn_mask_o         (scn_mask_o),
    .clr_single_o       (clr_single_o),
    .clr_scan_o         (clr_scan_o),
    .wr_err_o           (wr_err_o)
);

// File: tb/adc_xb_bridge_tb_top.sv
`timescale 1ns/100ps
module adc_xb_bridge_tb_top;

    localparam int DW = 16;
    localparam int NS = 7;

    logic bus_clk = 1'b0;
    logic slow_clk = 1'b0;
    logic use_sync = 1'b1;
    logic cnv_clk;
    logic bus_rst = 1'b1;
    logic cnv_rst = 1'b1;

    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_ready;
    logic          sa = 1'b0, ca = 1'b0, sp = 1'b0, cp = 1'b0;
    logic [NS*DW-1:0] src = '0;
    logic          clk_async, clk_inv;
    logic [DW-1:0] sgl_ctrl, scn_ctrl, scn_insel, scn_negsel, scn_mask;
    logic          stop_s, stop_c, clr_s, clr_c, err;

    int n_chk = 0;
    int n_err = 0;
    int n_stop_s = 0, n_stop_c = 0, n_clr_s = 0, n_clr_c = 0;
    logic [DW-1:0] shadow [5];
    bit async_mode = 1'b0;

    always #2   bus_clk  = ~bus_clk;
    always #3.2 slow_clk = ~slow_clk;
    assign cnv_clk = use_sync ? bus_clk : slow_clk;

    adc_xb_bridge #(.DATA_W(DW)) dut_i (
        .bus_clk(bus_clk), .bus_rst(bus_rst), .cnv_clk(cnv_clk), .cnv_rst(cnv_rst),
        .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_ready_o(bus_ready),
        .single_act_i(sa), .scan_act_i(ca), .single_trig_pend_i(sp), .scan_trig_pend_i(cp),
        .cnv_src_i(src), .clk_async_o(clk_async), .clk_inv_o(clk_inv),
        .sgl_ctrl_o(sgl_ctrl), .scn_ctrl_o(scn_ctrl), .scn_insel_o(scn_insel),
        .scn_negsel_o(scn_negsel), .scn_mask_o(scn_mask),
        .stop_single_o(stop_s), .stop_scan_o(stop_c),
        .clr_single_o(clr_s), .clr_scan_o(clr_c), .wr_err_o(err)
    );

    always @(posedge bus_clk) begin
        if (stop_s) n_stop_s++;
        if (stop_c) n_stop_c++;
    end
    always @(posedge cnv_clk) begin
        if (clr_s) n_clr_s++;
        if (clr_c) n_clr_c++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_stall(input string tag, input bit asy, input int waits);
        n_chk++;
        if (asy ? (waits < 1 || waits > 7) : (waits != 0)) begin
            n_err++;
            $display("FAIL %s stall actual=%0d expected=%s", tag, waits, asy ? "1..7" : "0");
        end
    endtask

    task automatic bus_op(input bit w, input logic [4:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] rd, output int waits);
        @(negedge bus_clk);
        bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
        waits = 0; rd = '0;
        forever begin
            #1;
            if (bus_ready) begin
                rd = bus_rdata;
                break;
            end
            waits++;
            if (waits > 60) begin
                n_chk++; n_err++;
                $display("FAIL R1 bus timeout actual=%0d expected=<=7", waits);
                break;
            end
            @(negedge bus_clk);
        end
        @(negedge bus_clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge bus_clk);
    endtask

    task automatic set_mode(input bit asy, input bit inv);
        logic [DW-1:0] rd; int w;
        bus_op(1'b1, 5'd0, {14'd0, inv, asy}, rd, w);
        idle(2);
        use_sync = ~asy;
        async_mode = asy;
        idle(4);
    endtask

    task automatic do_read_src(input int idx);
        logic [DW-1:0] rd, v; int w;
        v = DW'($urandom);
        src[idx*DW +: DW] = v;
        bus_op(1'b0, 5'(8 + idx), '0, rd, w);
        chk(async_mode ? "R1 data" : "R2 data", 32'(rd), 32'(v));
        chk_stall(async_mode ? "R1" : "R2", async_mode, w);
    endtask

    task automatic do_clear(input bit scan);
        logic [DW-1:0] rd; int w, bs, bc;
        bs = n_clr_s; bc = n_clr_c;
        bus_op(1'b1, scan ? 5'd16 : 5'd15, 16'h0001, rd, w);
        idle(4);
        chk_stall("R4", async_mode, w);
        chk("R4 single pulses", 32'(n_clr_s - bs), scan ? 0 : 1);
        chk("R4 scan pulses", 32'(n_clr_c - bc), scan ? 1 : 0);
    endtask

    task automatic do_guard(input int g, input logic [DW-1:0] d);
        logic [DW-1:0] rd; int w; bit busy;
        busy = (g == 0) ? (sa || sp) : (ca || cp);
        bus_op(1'b1, 5'(3 + g), d, rd, w);
        if (!busy) shadow[g] = d;
        bus_op(1'b0, 5'(3 + g), '0, rd, w);
        chk((g == 0) ? "R5 readback" : "R6 readback", 32'(rd), 32'(shadow[g]));
        chk_stall("R3", 1'b0, w);
        chk((g == 0) ? "R5 err" : "R6 err", 32'(err), 32'(busy));
        if (err) begin
            bus_op(1'b1, 5'd2, 16'h0004, rd, w);
            chk("R7 err cleared", 32'(err), 0);
        end
    endtask

    task automatic do_stop(input logic [1:0] bits);
        logic [DW-1:0] rd; int w, bs, bc;
        bs = n_stop_s; bc = n_stop_c;
        bus_op(1'b1, 5'd1, {14'd0, bits}, rd, w);
        idle(2);
        chk("R8 single stop", 32'(n_stop_s - bs), 32'(bits[0]));
        chk("R8 scan stop", 32'(n_stop_c - bc), 32'(bits[1]));
    endtask

    initial begin
        #400000;
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        int w;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 5; i++) shadow[i] = '0;
        idle(6);
        bus_rst = 1'b0; cnv_rst = 1'b0;
        idle(2);

        // R10 reset state
        chk("R10 async", 32'(clk_async), 0);
        chk("R10 inv", 32'(clk_inv), 0);
        chk("R10 err", 32'(err), 0);
        chk("R10 ctrl", 32'(sgl_ctrl | scn_ctrl | scn_insel | scn_negsel | scn_mask), 0);
        chk("R10 pulses", 32'({stop_s, stop_c, clr_s, clr_c}), 0);
        bus_op(1'b0, 5'd0, '0, rd, w);
        chk("R10 cfg read", 32'(rd), 0);
        chk_stall("R3", 1'b0, w);

        // R2 synchronous bypass
        do_read_src(0);
        do_read_src(6);
        do_clear(1'b0);

        // R9 mode bits
        bus_op(1'b1, 5'd0, 16'h0003, rd, w);
        idle(1);
        chk("R9 async out", 32'(clk_async), 1);
        chk("R9 inv out", 32'(clk_inv), 1);
        bus_op(1'b0, 5'd0, '0, rd, w);
        chk("R9 readback", 32'(rd), 3);
        set_mode(1'b1, 1'b0);
        chk("R9 inv cleared", 32'(clk_inv), 0);

        // R1 every crossed source in async mode
        for (int k = 0; k < NS; k++) do_read_src(k);
        do_clear(1'b1);
        do_clear(1'b0);
        bus_op(1'b0, 5'd2, '0, rd, w);
        chk_stall("R3", 1'b0, w);

        // R5 single guard, R7 stickiness and status read
        sa = 1'b1;
        bus_op(1'b1, 5'd3, 16'h1234, rd, w);
        chk("R5 dropped", 32'(sgl_ctrl), 0);
        bus_op(1'b1, 5'd0, 16'h0001, rd, w);
        chk("R7 still set", 32'(err), 1);
        bus_op(1'b0, 5'd2, '0, rd, w);
        chk("R7 status", 32'(rd), 32'h5);
        bus_op(1'b1, 5'd2, 16'h0003, rd, w);
        chk("R7 bit2 needed", 32'(err), 1);
        bus_op(1'b1, 5'd2, 16'h0004, rd, w);
        chk("R7 cleared", 32'(err), 0);
        sa = 1'b0; sp = 1'b1;
        do_guard(0, 16'h00aa);
        sp = 1'b0;
        do_guard(0, 16'h0bee);

        // R6 scan guard independent of single flags
        cp = 1'b1;
        do_guard(4, 16'hf00f);
        cp = 1'b0; sa = 1'b1; sp = 1'b1;
        do_guard(2, 16'h3c3c);
        sa = 1'b0; sp = 1'b0; ca = 1'b1;
        do_guard(1, 16'h7777);
        ca = 1'b0;

        // R8 stops
        do_stop(2'b11);
        do_stop(2'b01);
        do_stop(2'b10);

        // mixed random traffic
        for (int it = 0; it < 80; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 4) begin
                do_read_src($urandom_range(0, NS - 1));
            end else if (op < 5) begin
                do_clear(1'($urandom_range(0, 1)));
            end else if (op < 8) begin
                sa = ($urandom_range(0, 2) == 0);
                sp = ($urandom_range(0, 3) == 0);
                ca = ($urandom_range(0, 2) == 0);
                cp = ($urandom_range(0, 3) == 0);
                do_guard($urandom_range(0, 4), DW'($urandom));
                sa = 1'b0; sp = 1'b0; ca = 1'b0; cp = 1'b0;
            end else if (op < 9) begin
                do_stop(2'($urandom_range(0, 3)));
            end else begin
                set_mode(~async_mode, 1'($urandom_range(0, 1)));
                chk("R9 mode", 32'(clk_async), 32'(async_mode));
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule